// File: doc/BRIEF.md
# Debug Clock and Reset Generator

This block turns one fast functional clock and two active-low reset requests into the clocks and reset used by a digital core that is debugged in its application. One request comes from a chip pin and the other from a debug-port reset command; either one resets the block. The block produces three outputs: the fast clock passed through a gate, a slow clock at one eighth of the fast rate, and an internal active-low reset that changes only on slow-clock rising edges. Downstream logic uses that internal reset as a synchronous reset.

Both output clocks are held low during reset. When reset is released they start together with a rising edge, because the divider phase is held at zero while reset is active. Either clock can be switched off by a power-down control bit or by a stop request from breakpoint logic. Each gate's enable is updated only while the clock it controls is low, so a gate can never cut a pulse short. The clocks are modelled as gated enable-qualified signals, so the block is suitable for simulation.

Top module: `dbg_clkrst_gen`

## Requirements
- R1: While running and ungated, `clk_slow_o` has a period of 8 fast-clock periods. It is high for 4 periods and low for 4.
- R2: After reset is released, `clk_fast_o` and `clk_slow_o` both give their first rising edge at the same instant. That instant is the third rising edge of `clk_fast_i` after the release.
- R3: The block is in reset whenever `rst_pin_n_i` or `rst_dbg_n_i` is low (value 0). Each of the two requests resets it on its own.
- R4: When `pwr_down_i` or `stop_req_i` is 1 after fast rising edge k, `clk_fast_o` gives no pulse at rising edge k+1; when both are 0, it gives a pulse there. While either input is held at 1, `clk_slow_o` gives no pulses.
- R5: `rst_int_n_o` stays low until the third rising edge of `clk_slow_o` after reset is released, and rises exactly at that edge. It changes only on slow-clock rising edges.
- R6: Gating never shortens a pulse. Every `clk_fast_o` high pulse lasts half a fast period, and every `clk_slow_o` high pulse lasts 4 fast periods.
- R7: Reset takes effect at once, without waiting for a clock edge: all three outputs go low immediately. Release passes through two fast-clock synchronizer stages, and once released the synchronized reset stays released until the next reset.
- R8: The divider phase is held at zero during reset and keeps counting while the clocks are gated. Consecutive `clk_slow_o` rising edges are therefore always a whole multiple of 8 fast periods apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast_i | input | 1 | Fast functional clock |
| rst_pin_n_i | input | 1 | Reset request from the chip pin, active low |
| rst_dbg_n_i | input | 1 | Reset request from the debug port, active low |
| pwr_down_i | input | 1 | Power-down control bit; 1 gates both clocks |
| stop_req_i | input | 1 | Stop-clocks request from breakpoint logic; 1 gates both clocks |
| clk_fast_o | output | 1 | Gated fast clock |
| clk_slow_o | output | 1 | Gated fast clock divided by eight |
| rst_int_n_o | output | 1 | Internal reset aligned to the slow clock, active low |

## Verification
The bench measures the time from reset release to the first rise of each output. A divider that was not held at zero would start the two clocks apart, and a shortened synchronizer would show up as the wrong latency. A random sequence of power-down and stop pulses, applied cycle by cycle, is compared with the expected presence of each fast pulse. Throughout, the bench watches pulse widths and slow-clock spacing, so an enable sampled at the wrong time shows up as a short pulse and a divider that stalls under gating shows up as a phase slip. The debug-port reset and the pin reset are each asserted mid-run at random phases, which exposes an input that is ignored, an assertion that waits for a clock edge, or an internal reset released on the wrong slow edge.

// File: rtl/dbgcr_pkg.sv
`timescale 1ns/1ps
package dbgcr_pkg;
  localparam int unsigned NUM_GATES = 2;
  typedef enum int unsigned {
    GATE_FAST = 0,
    GATE_SLOW = 1
  } gate_idx_e;
endpackage

// File: rtl/dbgcr_rst_sync.sv
`timescale 1ns/1ps
module dbgcr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic sync_n_o
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) sh_q <= '0;
    else           sh_q <= sh_d;
  end

  assign sync_n_o = sh_q[STAGES-1];

  // R7: once released, stays released until the asynchronous reset returns
  a_r7_release_sticky: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    sync_n_o |=> sync_n_o);
endmodule

// File: rtl/dbgcr_div.sv
`timescale 1ns/1ps
module dbgcr_div #(
  parameter int unsigned RATIO = 8
) (
  input  logic clk_i,
  input  logic arst_n_i,
  input  logic run_i,
  output logic slow_o,
  output logic tick_o
);
  localparam int unsigned CW   = (RATIO > 2) ? $clog2(RATIO) : 1;
  localparam int unsigned HALF = RATIO / 2;
  localparam logic [CW-1:0] LAST  = CW'(RATIO - 1);
  localparam logic [CW-1:0] HALFV = CW'(HALF);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          slow_q, slow_d;

  always_comb begin
    if (!run_i) begin
      cnt_d  = '0;
      slow_d = 1'b0;
    end else begin
      cnt_d  = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      slow_d = (cnt_q < HALFV);
    end
  end

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) begin
      cnt_q  <= '0;
      slow_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      slow_q <= slow_d;
    end
  end

  assign slow_o = slow_q;
  assign tick_o = run_i && (cnt_q == '0);

  // R8: phase pinned to zero and slow level low while not running
  a_r8_hold_zero: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    !run_i |=> (cnt_q == '0) && !slow_q);
  // R1: slow level rises at phase zero and falls at half period
  a_r1_rise_at_zero: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    (run_i && cnt_q == '0) |=> slow_q);
  a_r1_fall_at_half: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    (run_i && cnt_q == HALFV) |=> !slow_q);
endmodule

// File: rtl/dbgcr_clk_gate.sv
`timescale 1ns/1ps
module dbgcr_clk_gate (
  input  logic clk_i,
  input  logic arst_n_i,
  input  logic src_i,
  input  logic allow_i,
  input  logic en_i,
  output logic gclk_o
);
  logic en_q, en_d;

  always_comb begin
    en_d = allow_i ? en_i : en_q;
  end

  always_ff @(negedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) en_q <= 1'b0;
    else           en_q <= en_d;
  end

  assign gclk_o = src_i & en_q;

  // R6: the enable moves only inside the window where the gated source is low
  a_r6_window_only: assert property (@(negedge clk_i) disable iff (!arst_n_i)
    $changed(en_q) |-> $past(allow_i));
  // R4: a blocked request closes the gate at the next update
  a_r4_block_closes: assert property (@(negedge clk_i) disable iff (!arst_n_i)
    (allow_i && !en_i) |=> !en_q);
endmodule

// File: rtl/dbgcr_rst_out.sv
`timescale 1ns/1ps
module dbgcr_rst_out #(
  parameter int unsigned STAGES = 3
) (
  input  logic clk_i,
  input  logic arst_n_i,
  input  logic tick_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = tick_i ? {sh_q[STAGES-2:0], 1'b1} : sh_q;
  end

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) sh_q <= '0;
    else           sh_q <= sh_d;
  end

  assign rst_n_o = sh_q[STAGES-1];

  // R5: internal reset releases only on a slow-clock rising edge
  a_r5_release_on_tick: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    $rose(rst_n_o) |-> $past(tick_i));
endmodule

// File: rtl/dbg_clkrst_gen.sv
`timescale 1ns/1ps
module dbg_clkrst_gen #(
  parameter int unsigned DIV_RATIO    = 8,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned RST_STAGES   = 3
) (
  input  logic clk_fast_i,
  input  logic rst_pin_n_i,
  input  logic rst_dbg_n_i,
  input  logic pwr_down_i,
  input  logic stop_req_i,
  output logic clk_fast_o,
  output logic clk_slow_o,
  output logic rst_int_n_o
);
  import dbgcr_pkg::*;

  logic rst_n;
  logic run;
  logic slow_lvl;
  logic slow_tick;
  logic en_req;
  logic [NUM_GATES-1:0] src_vec, allow_vec, gclk_vec;

  // R3: either request resets the block
  assign rst_n  = rst_pin_n_i & rst_dbg_n_i;
  assign en_req = run & ~pwr_down_i & ~stop_req_i;

  dbgcr_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_fast_i),
    .arst_n_i (rst_n),
    .sync_n_o (run)
  );

  dbgcr_div #(.RATIO(DIV_RATIO)) u_div (
    .clk_i    (clk_fast_i),
    .arst_n_i (rst_n),
    .run_i    (run),
    .slow_o   (slow_lvl),
    .tick_o   (slow_tick)
  );

  assign src_vec[GATE_FAST]   = clk_fast_i;
  assign allow_vec[GATE_FAST] = 1'b1;
  assign src_vec[GATE_SLOW]   = slow_lvl;
  assign allow_vec[GATE_SLOW] = ~slow_lvl;

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
    dbgcr_clk_gate u_gate (
      .clk_i    (clk_fast_i),
      .arst_n_i (rst_n),
      .src_i    (src_vec[g]),
      .allow_i  (allow_vec[g]),
      .en_i     (en_req),
      .gclk_o   (gclk_vec[g])
    );
  end

  assign clk_fast_o = gclk_vec[GATE_FAST];
  assign clk_slow_o = gclk_vec[GATE_SLOW];

  dbgcr_rst_out #(.STAGES(RST_STAGES)) u_rst (
    .clk_i    (clk_fast_i),
    .arst_n_i (rst_n),
    .tick_i   (slow_tick),
    .rst_n_o  (rst_int_n_o)
  );
endmodule

// File: tb/dbg_clkrst_gen_tb_top.sv
`timescale 1ns/1ps
module dbg_clkrst_gen_tb_top;
  logic clk = 1'b0;
  logic rst_pin_n, rst_dbg_n, pwr, stop;
  logic clk_fast_o, clk_slow_o, rst_int_n_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  dbg_clkrst_gen dut_i (
    .clk_fast_i  (clk),
    .rst_pin_n_i (rst_pin_n),
    .rst_dbg_n_i (rst_dbg_n),
    .pwr_down_i  (pwr),
    .stop_req_i  (stop),
    .clk_fast_o  (clk_fast_o),
    .clk_slow_o  (clk_slow_o),
    .rst_int_n_o (rst_int_n_o)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint to_ps(input realtime t);
    return longint'(t * 1000.0);
  endfunction

  function automatic bit exp_rint(input int rise_idx);
    return rise_idx >= 3;
  endfunction

  // monitors
  bit      mon_en = 0, init_phase = 0;
  bit      first_fast_seen = 0, first_slow_seen = 0;
  realtime t_fr, t_sr, t_prev_slow, t_first_fast, t_first_slow, t_second_slow;
  int      slow_rises = 0, fast_rises = 0;
  int      fast_bad = 0, slow_bad = 0, phase_bad = 0;

  always @(posedge clk_fast_o) begin
    t_fr = $realtime;
    fast_rises++;
    if (!first_fast_seen) begin
      first_fast_seen = 1;
      t_first_fast = $realtime;
    end
  end

  always @(negedge clk_fast_o) begin
    if (mon_en && to_ps($realtime - t_fr) != 2500) fast_bad++;
  end

  always @(posedge clk_slow_o) begin
    t_sr = $realtime;
    slow_rises++;
    if (!first_slow_seen) begin
      first_slow_seen = 1;
      t_first_slow = $realtime;
    end else begin
      if (slow_rises == 2) t_second_slow = $realtime;
      if (mon_en && (to_ps($realtime - t_prev_slow) % 40000) != 0) phase_bad++;
    end
    t_prev_slow = $realtime;
    if (init_phase && slow_rises <= 4) begin
      #1;
      // R5: internal reset value just after each of the first slow rises
      chk(rst_int_n_o == exp_rint(slow_rises), "R5 rst_int_n after slow rise",
          longint'(rst_int_n_o), longint'(exp_rint(slow_rises)));
    end
  end

  always @(negedge clk_slow_o) begin
    if (mon_en && to_ps($realtime - t_sr) != 20000) slow_bad++;
  end

  task automatic clear_mon();
    first_fast_seen = 0;
    first_slow_seen = 0;
    slow_rises = 0;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  // release reset and check start-up alignment (R2, R1, R5)
  task automatic release_and_check(input bit use_pin);
    realtime t_rel;
    clear_mon();
    @(posedge clk); #1;
    init_phase = 1;
    if (use_pin) rst_pin_n = 1'b1; else rst_dbg_n = 1'b1;
    t_rel = $realtime;
    mon_en = 1;
    wait (slow_rises >= 4);
    #2;
    init_phase = 0;
    chk(to_ps(t_first_fast - t_rel) == 14000, "R2 fast start latency",
        to_ps(t_first_fast - t_rel), 14000);
    chk(to_ps(t_first_slow) == to_ps(t_first_fast), "R2 slow start aligned",
        to_ps(t_first_slow), to_ps(t_first_fast));
    chk(to_ps(t_second_slow - t_first_slow) == 40000, "R1 slow period",
        to_ps(t_second_slow - t_first_slow), 40000);
  endtask

  task automatic assert_reset(input bit use_pin, input string tag);
    @(posedge clk); #1;
    mon_en = 0;
    if (use_pin) rst_pin_n = 1'b0; else rst_dbg_n = 1'b0;
    #0.5;
    chk(clk_fast_o == 1'b0, {tag, " fast low at once"}, longint'(clk_fast_o), 0);
    chk(clk_slow_o == 1'b0, {tag, " slow low at once"}, longint'(clk_slow_o), 0);
    chk(rst_int_n_o == 1'b0, {tag, " rst_int low at once"}, longint'(rst_int_n_o), 0);
    cycles(6);
    chk(clk_fast_o == 1'b0, {tag, " fast held in reset"}, longint'(clk_fast_o), 0);
  endtask

  task automatic gate_hold(input bit use_pwr, input string tag);
    int s0, f0, s1;
    if (use_pwr) pwr = 1'b1; else stop = 1'b1;
    cycles(24);
    s0 = slow_rises; f0 = fast_rises;
    cycles(40);
    chk(slow_rises == s0, {tag, " no slow pulses while held"}, slow_rises - s0, 0);
    chk(fast_rises == f0, {tag, " no fast pulses while held"}, fast_rises - f0, 0);
    if (use_pwr) pwr = 1'b0; else stop = 1'b0;
    cycles(16);
    s1 = slow_rises;
    cycles(16);
    chk(slow_rises - s1 == 2, "R1 two slow rises per 16 fast cycles after ungating",
        slow_rises - s1, 2);
  endtask

  initial begin
    bit exp_pulse;
    void'($urandom(32'h5EED_C10C));
    rst_pin_n = 1'b0; rst_dbg_n = 1'b1; pwr = 1'b0; stop = 1'b0;
    cycles(4);
    #0.2;
    // R7: reset state, sampled while the input clock is high
    chk(clk === 1'b1, "R7 sample point clock high", longint'(clk), 1);
    chk(clk_fast_o == 1'b0, "R7 reset fast low", longint'(clk_fast_o), 0);
    chk(clk_slow_o == 1'b0, "R7 reset slow low", longint'(clk_slow_o), 0);
    chk(rst_int_n_o == 1'b0, "R7 reset rst_int low", longint'(rst_int_n_o), 0);

    release_and_check(1'b1);

    // R4: random cycle-by-cycle gating of the fast clock
    exp_pulse = 1'b1;
    for (int i = 0; i < 400; i++) begin
      @(posedge clk); #1;
      chk(clk_fast_o == exp_pulse, "R4 fast pulse presence", longint'(clk_fast_o),
          longint'(exp_pulse));
      pwr  = ($urandom % 5) == 0;
      stop = ($urandom % 4) == 0;
      exp_pulse = !(pwr || stop);
    end
    pwr = 1'b0; stop = 1'b0;
    cycles(16);

    gate_hold(1'b0, "R4 stop");
    gate_hold(1'b1, "R4 power-down");

    // R3: debug-port reset alone resets and restarts aligned
    assert_reset(1'b0, "R3 debug reset");
    release_and_check(1'b0);

    // R3/R7: pin reset at random phases
    for (int k = 0; k < 3; k++) begin
      cycles(int'($urandom % 8) + 1);
      assert_reset(1'b1, "R3 pin reset");
      release_and_check(1'b1);
    end

    // random stop bursts then integrity checks (R6, R8)
    for (int i = 0; i < 300; i++) begin
      @(posedge clk); #1;
      stop = ($urandom % 3) == 0;
    end
    stop = 1'b0;
    cycles(20);
    chk(fast_bad == 0, "R6 fast pulse widths", fast_bad, 0);
    chk(slow_bad == 0, "R6 slow pulse widths", slow_bad, 0);
    chk(phase_bad == 0, "R8 slow phase kept under gating", phase_bad, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule